// File: doc/BRIEF.md
# Queued Burst Read Engine with Throughput Timer

This block is a read-only AXI4 master with a 64-bit data path. It measures how fast a memory slave can stream data back. A one-cycle start strobe and a two-bit size code launch a job. The job reads a fixed-size region, starting at a fixed base address, as a sequence of 16-beat incrementing bursts. Every returned beat is passed to a 512-entry by 64-bit local buffer through a simple write port, and the buffer address wraps.

The engine does not wait for the last beat of one burst before requesting the next. It presents a new read address on every cycle that the slave is ready, so several bursts are in flight at once. The slave's access latency is therefore paid about once per stream instead of once per burst.

A job repeats the transfer eight times. After each repetition the engine reports the number of clock cycles from the first address request to the last beat of the final burst. The last report also carries a job-done pulse. A sticky flag records any beat returned with a non-OKAY response.

Top module: `axi_burst_reader`

## Requirements
- R1: The size code selects the bursts per repetition: 0 gives 16 (2 KB), 1 gives 32 (4 KB), 2 gives 64 (8 KB), 3 gives 128 (16 KB). Every request carries length field 15 (16 beats), size field 3 (8 bytes) and burst type 1 (incrementing).
- R2: Within each repetition the first request address is 0x01000000, and each later request is 128 above the one before.
- R3: A request that is not accepted keeps its valid and its address unchanged. After an accepted request, the next request is valid in the following cycle while bursts remain, without waiting for returned data.
- R4: The engine places no limit of its own on outstanding bursts. Against a slave that accepts N addresses before stalling, N bursts are outstanding at the peak.
- R5: The read-data ready output is high in every cycle.
- R6: Each returned beat produces one buffer write carrying that beat's data. Within a repetition the write addresses run 0, 1, 2 and so on, modulo 512.
- R7: One cycle after the final beat of a repetition, a report pulse presents the inclusive cycle count and the repetition index 0 to 7. The count runs from the first cycle that a request is valid to the cycle of the final beat.
- R8: A job consists of exactly eight repetitions. Each new repetition presents a request in the cycle after the previous one's final beat. The done pulse coincides with the eighth report, and busy then falls.
- R9: A start strobe while busy is ignored. The running job keeps its size and its report count.
- R10: A beat with a non-zero response sets the error flag. The flag stays set until the next accepted start clears it.
- R11: After reset the engine is idle, with no valid request, no buffer write, no report, no done pulse and the error flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job trigger strobe |
| size_sel | input | 2 | Transfer size code |
| busy | output | 1 | Job in progress |
| done | output | 1 | Pulse with the eighth report |
| err | output | 1 | Sticky non-OKAY response flag |
| meas_valid | output | 1 | Report pulse |
| meas_index | output | 3 | Repetition number of the report |
| meas_cycles | output | 32 | Measured cycles of the repetition |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | 32 | Read address |
| arlen | output | 8 | Burst length minus one |
| arsize | output | 3 | Beat size code |
| arburst | output | 2 | Burst type |
| arid | output | 4 | Transaction ID, always zero |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | 64 | Read data |
| rresp | input | 2 | Read response |
| rlast | input | 1 | Last beat of burst |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | 9 | Buffer write address |
| buf_wdata | output | 64 | Buffer write data |

## Verification
The assertions take for granted a slave that returns data in order. It never returns a last beat unless a burst is outstanding, and it returns nothing while the engine is idle. The bench's slave model respects both conditions by construction. It queues the addresses it has accepted and lowers its ready when four or five are pending. It starts returning a burst only after a fixed latency has passed, and it sends exactly 16 beats for each accepted address. The bench sweeps every size code against two accept limits and latencies, once each with an injected error response and with a start strobe during a busy job.

// File: rtl/axi_burst_reader.sv
module axi_burst_reader #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 64,
  parameter int          ID_W      = 4,
  parameter int          BUF_AW    = 9,
  parameter int          BEATS     = 16,
  parameter int          RUNS      = 8,
  parameter int          CNT_W     = 32,
  parameter int          MIN_BYTES = 2048,
  parameter logic [31:0] BASE_ADDR = 32'h0100_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [1:0]                 size_sel,
  output logic                       busy,
  output logic                       done,
  output logic                       err,
  output logic                       meas_valid,
  output logic [$clog2(RUNS)-1:0]    meas_index,
  output logic [CNT_W-1:0]           meas_cycles,
  output logic                       arvalid,
  input  logic                       arready,
  output logic [ADDR_W-1:0]          araddr,
  output logic [7:0]                 arlen,
  output logic [2:0]                 arsize,
  output logic [1:0]                 arburst,
  output logic [ID_W-1:0]            arid,
  input  logic                       rvalid,
  output logic                       rready,
  input  logic [DATA_W-1:0]          rdata,
  input  logic [1:0]                 rresp,
  input  logic                       rlast,
  output logic                       buf_we,
  output logic [BUF_AW-1:0]          buf_addr,
  output logic [DATA_W-1:0]          buf_wdata
);
  localparam int BYTES       = DATA_W / 8;
  localparam int BURST_BYTES = BEATS * BYTES;
  localparam int MIN_BURSTS  = MIN_BYTES / BURST_BYTES;
  localparam int MAX_BURSTS  = MIN_BURSTS << 3;
  localparam int BW          = $clog2(MAX_BURSTS) + 1;
  localparam int RW          = $clog2(RUNS);

  logic              busy_q, done_q, err_q, mv_q;
  logic [RW-1:0]     run_q, mi_q;
  logic [CNT_W-1:0]  cnt_q, mc_q;
  logic [BW-1:0]     total_q, req_q, out_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BUF_AW-1:0] wptr_q;

  wire ar_hs     = arvalid && arready;
  wire r_hs      = busy_q && rvalid;
  wire r_last_hs = r_hs && rlast;
  wire final_b   = r_last_hs && (out_q == BW'(1)) && (req_q == total_q);

  assign arvalid     = busy_q && (req_q != total_q);
  assign araddr      = addr_q;
  assign arlen       = 8'(BEATS - 1);
  assign arsize      = 3'($clog2(BYTES));
  assign arburst     = 2'b01;
  assign arid        = '0;
  assign rready      = 1'b1;
  assign buf_we      = r_hs;
  assign buf_addr    = wptr_q;
  assign buf_wdata   = rdata;
  assign busy        = busy_q;
  assign done        = done_q;
  assign err         = err_q;
  assign meas_valid  = mv_q;
  assign meas_index  = mi_q;
  assign meas_cycles = mc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; mv_q <= 1'b0;
      run_q <= '0; mi_q <= '0; cnt_q <= '0; mc_q <= '0;
      total_q <= '0; req_q <= '0; out_q <= '0;
      addr_q <= BASE_ADDR; wptr_q <= '0;
    end else begin
      done_q <= 1'b0;
      mv_q   <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          total_q <= BW'(MIN_BURSTS) << size_sel;
          req_q   <= '0;
          out_q   <= '0;
          addr_q  <= BASE_ADDR;
          wptr_q  <= '0;
          cnt_q   <= '0;
          run_q   <= '0;
          err_q   <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (ar_hs) begin
          req_q  <= req_q + 1'b1;
          addr_q <= addr_q + ADDR_W'(BURST_BYTES);
        end
        case ({ar_hs, r_last_hs})
          2'b10:   out_q <= out_q + 1'b1;
          2'b01:   out_q <= out_q - 1'b1;
          default: out_q <= out_q;
        endcase
        if (r_hs) begin
          wptr_q <= wptr_q + 1'b1;
          if (rresp != 2'b00) err_q <= 1'b1;
        end
        if (final_b) begin
          mc_q   <= cnt_q + 1'b1;
          mi_q   <= run_q;
          mv_q   <= 1'b1;
          req_q  <= '0;
          out_q  <= '0;
          addr_q <= BASE_ADDR;
          wptr_q <= '0;
          cnt_q  <= '0;
          if (run_q == RW'(RUNS - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end
      end
    end
  end

  p_ar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && !arready |=> arvalid && $stable(araddr));
  p_ar_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ar_hs |=> !arvalid || (araddr == $past(araddr) + ADDR_W'(BURST_BYTES)));
  p_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ar_hs && (req_q + 1'b1 != total_q) |=> arvalid);
  p_out_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> out_q <= req_q);
  p_last_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    r_last_hs |-> out_q != '0);
  p_report_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mv_q |-> mc_q >= CNT_W'(BEATS * MIN_BURSTS));
  p_done_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> mv_q && !busy_q && (mi_q == RW'(RUNS - 1)));
  p_size_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(total_q));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(start && !busy_q) |=> err_q);
endmodule

// File: tb/axi_burst_reader_tb.sv
module axi_burst_reader_tb;
  localparam logic [31:0] BASE = 32'h0100_0000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] size_sel = 2'd0;
  logic busy, done, err, meas_valid, arvalid, rready, buf_we;
  logic [2:0] meas_index, arsize;
  logic [31:0] meas_cycles, araddr;
  logic [7:0] arlen;
  logic [1:0] arburst, rresp;
  logic [3:0] arid;
  logic [8:0] buf_addr;
  logic [63:0] rdata, buf_wdata;
  logic arready, rvalid, rlast;

  always #2.5 clk = ~clk;

  axi_burst_reader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
    .busy(busy), .done(done), .err(err), .meas_valid(meas_valid),
    .meas_index(meas_index), .meas_cycles(meas_cycles),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
    .arsize(arsize), .arburst(arburst), .arid(arid),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp), .rlast(rlast),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata));

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model
  int lim = 4, lat = 3, inject = 0;
  logic [31:0] q_addr [8];
  int q_t [8];
  int hd = 0, tl = 0, qn = 0, sbeat = 0, jobbeat = 0, scyc = 0;
  initial begin
    arready = 1'b0; rvalid = 1'b0; rlast = 1'b0; rdata = '0; rresp = 2'b00;
    forever begin
      @(posedge clk);
      scyc++;
      if (!rst_n) begin
        hd = 0; tl = 0; qn = 0; sbeat = 0;
        arready <= 1'b0; rvalid <= 1'b0; rlast <= 1'b0;
      end else begin
        if (arvalid && arready) begin
          q_addr[tl] = araddr; q_t[tl] = scyc; tl = (tl + 1) % 8; qn++;
        end
        if (rvalid) begin
          sbeat++; jobbeat++;
          if (sbeat == 16) begin sbeat = 0; hd = (hd + 1) % 8; qn--; end
        end
        arready <= (qn < lim);
        if (qn > 0 && scyc >= q_t[hd] + lat) begin
          rvalid <= 1'b1;
          rdata  <= 64'(q_addr[hd]) + 64'(sbeat * 8);
          rlast  <= (sbeat == 15);
          rresp  <= (inject != 0 && jobbeat == 37) ? 2'b10 : 2'b00;
        end else begin
          rvalid <= 1'b0; rlast <= 1'b0; rresp <= 2'b00;
        end
      end
    end
  end

  // port monitor
  int ncyc = 0, exp_total = 16, m_req = 0, m_ret = 0, m_beat = 0, m_out = 0, m_max = 0;
  int m_first = 0, run_no = 0, exp_meas = 0;
  bit first_seen = 0, pending = 0, prev_hs = 0, prev_stall = 0, restart = 0, done_seen = 0;
  logic [31:0] prev_addr = '0;
  initial forever begin
    @(negedge clk);
    ncyc++;
    if (rst_n && busy) begin
      check(rready, "R5 rready high", rready, 1);
      if (restart) check(arvalid, "R8 next run starts at once", arvalid, 1);
      restart = 0;
      if (arvalid && !first_seen) begin first_seen = 1; m_first = ncyc; end
      if (prev_stall) check(arvalid && araddr == prev_addr, "R3 held request", araddr, prev_addr);
      if (prev_hs && m_req < exp_total) check(arvalid, "R3 back-to-back request", arvalid, 1);
      prev_hs = arvalid && arready;
      prev_stall = arvalid && !arready;
      prev_addr = araddr;
      if (arvalid && arready) begin
        check(araddr == BASE + 32'(m_req * 128), "R2 request address", araddr, BASE + 32'(m_req * 128));
        check(arlen == 8'd15 && arsize == 3'd3 && arburst == 2'd1 && arid == 4'd0,
              "R1 request fields", {arlen, arsize, arburst}, {8'd15, 3'd3, 2'd1});
        m_req++; m_out++;
        if (m_out > m_max) m_max = m_out;
      end
      check(buf_we == rvalid, "R6 buffer write enable", buf_we, rvalid);
      if (rvalid) begin
        check(buf_addr == 9'(m_beat), "R6 buffer address", buf_addr, 9'(m_beat));
        check(buf_wdata == rdata && rdata == 64'(BASE) + 64'(m_beat * 8),
              "R6 buffer data", buf_wdata, 64'(BASE) + 64'(m_beat * 8));
        m_beat++;
        if (rlast) begin
          m_ret++; m_out--;
          if (m_ret == exp_total) begin
            check(m_req == exp_total && m_beat == exp_total * 16, "R1 bursts per run", m_req, exp_total);
            exp_meas = ncyc - m_first + 1; pending = 1; restart = (run_no < 7);
            m_req = 0; m_ret = 0; m_beat = 0; m_out = 0; first_seen = 0; prev_hs = 0; prev_stall = 0;
          end
        end
      end
    end
    if (rst_n && meas_valid) begin
      check(pending, "R7 report follows final beat", pending, 1);
      check(meas_cycles == 32'(exp_meas), "R7 measured cycles", meas_cycles, exp_meas);
      check(meas_index == 3'(run_no), "R7 report index", meas_index, run_no);
      check(done == (run_no == 7), "R8 done with eighth report", done, run_no == 7);
      pending = 0; run_no++;
      if (done) done_seen = 1;
    end
  end

  task automatic run_job(input int sz, input bit poke, input bit inj);
    exp_total = 16 << sz; run_no = 0; m_max = 0; done_seen = 0;
    inject = inj; jobbeat = 0;
    @(negedge clk); start = 1'b1; size_sel = 2'(sz);
    @(negedge clk); start = 1'b0; size_sel = 2'(3 - sz);
    check(busy && !err, "R10 start clears error", err, 0);
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy, "R9 busy during poke", busy, 1);
    end
    while (!done_seen) @(negedge clk);
    @(negedge clk);
    check(run_no == 8 && !busy, "R8 eight runs then idle", run_no, 8);
    check(m_max == lim, "R4 peak outstanding", m_max, lim);
    check(err == inj, "R10 error flag", err, inj);
    repeat (3) @(negedge clk);
    check(run_no == 8 && !busy, "R9 no extra runs", run_no, 8);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(!busy && !arvalid && !buf_we && !meas_valid && !done && !err,
          "R11 reset state", {busy, arvalid, buf_we, meas_valid, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !arvalid && !err, "R11 idle after reset", {busy, arvalid, err}, 0);
    for (int cfg = 0; cfg < 2; cfg++) begin
      lim = (cfg == 0) ? 4 : 5;
      lat = (cfg == 0) ? 3 : 12;
      for (int sz = 0; sz < 4; sz++)
        run_job(sz, sz == 1, sz == 2);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule